// File: doc/BRIEF.md
# Addressable Cascadable Delay Shift Register

This block delays a single-bit serial stream by a selectable number of clock-enabled cycles. It is built from chained segments of sixteen stages each. A binary tap address picks any stage of the whole chain, and that stage appears combinationally on the tap output. Each segment also drives a fixed output that always carries its own last stage. That output feeds the next segment and is visible at the block edge, so deeper chains can be formed outside the block.

The number of segments is a parameter from one to four, which gives up to 64 stages. A second parameter adds one flip-flop after the tap multiplexer. That flip-flop moves on the same clock enable as the stages, so it adds exactly one more enabled cycle of delay. The block has no reset and no load path. Its contents are whatever was last shifted in, so a pipeline that uses it for timing balance must flush it with valid data before it relies on the tap.

Top module: `srl_delay_line`

## Requirements
- R1: On a rising clock edge with `shift_en` high, stage 0 takes `din` and every stage j takes the previous value of stage j-1. Stage 0 is therefore the `din` value sampled at the most recent enabled edge.
- R2: On a rising clock edge with `shift_en` low, no stage changes, whatever `din` does. `tap_out` (for any address), `casc_out` and `tap_reg_out` keep their values.
- R3: `tap_out` is combinational in `tap_addr` and shows stage `tap_addr`. This equals the `din` value from `tap_addr`+1 enabled edges earlier. A change of address takes effect in the same cycle, with no clock edge needed.
- R4: `casc_out[k]` always carries stage 16*k+15, the last stage of segment k, independent of `tap_addr`. It equals `din` delayed by 16*(k+1) enabled edges.
- R5: Segments are chained: the serial input of segment k is `casc_out[k-1]`. In `tap_addr`, bits [ADDR_W-1:4] select the segment and bits [3:0] select the stage within it, so stage 16*k+j is stage j of segment k. The total delay reaches 16*SEGS enabled edges. An address at or beyond 16*SEGS drives `tap_out` to 0.
- R6: With TAP_REG=1, `tap_reg_out` loads the value of `tap_out` at each enabled edge and holds otherwise, adding one enabled cycle to the addressed delay. With TAP_REG=0, `tap_reg_out` equals `tap_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all segments and the tap register |
| shift_en | input | 1 | Clock enable for every stage and the tap register; tie high if unused |
| din | input | 1 | Serial data entering stage 0 |
| tap_addr | input | ADDR_W | Stage selected for the tap; upper bits pick the segment, low four bits pick the stage |
| tap_out | output | 1 | Combinational value of the addressed stage |
| tap_reg_out | output | 1 | Tap value after the optional enabled flip-flop |
| casc_out | output | SEGS | Last stage of each segment, bit k for segment k |

## Verification
The main overlap is a change of tap address in the same cycle as an enabled shift, with the clock enable also gated off on random cycles. The bench changes `din`, `shift_en` and `tap_addr` together at every falling edge. It then checks the tap against a history queue of the bits actually accepted. It also checks the registered tap against the tap value held at the edge under the address that was present then. A second overlap is `din` toggling while `shift_en` is low. That case is judged by sweeping every address afterwards and confirming that nothing moved.

// File: rtl/srl_pkg.sv
package srl_pkg;

    // Stages in one segment and the address bits that index them.
    localparam int SEG_LEN  = 16;
    localparam int IDX_W    = 4;
    localparam int MAX_SEGS = 4;

    // Width of the full tap address for a chain of the given segment count.
    function automatic int chain_addr_w(input int segs);
        return $clog2(SEG_LEN * segs);
    endfunction

    // Width of the segment-select field (at least one bit).
    function automatic int seg_sel_w(input int segs);
        int w;
        w = chain_addr_w(segs) - IDX_W;
        return (w > 0) ? w : 1;
    endfunction

endpackage

// File: rtl/srl_segment.sv
module srl_segment
    import srl_pkg::*;
(
    input  logic             clk,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [IDX_W-1:0] tap_idx,
    output logic             tap_bit,
    output logic             last_bit
);

    typedef struct packed {
        logic [SEG_LEN-1:0] stg;
    } seg_state_t;

    seg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.stg = {state_q.stg[SEG_LEN-2:0], ser_in};
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign tap_bit  = state_q.stg[tap_idx];
    assign last_bit = state_q.stg[SEG_LEN-1];

endmodule

// File: rtl/srl_tap_select.sv
module srl_tap_select
    import srl_pkg::*;
#(
    parameter  int SEGS  = 4,
    localparam int SEL_W = seg_sel_w(SEGS)
) (
    input  logic [SEGS-1:0]  seg_taps,
    input  logic [SEL_W-1:0] seg_sel,
    output logic             tap_bit
);

    // Unmatched selects (beyond the last segment) leave the output at 0.
    always_comb begin
        tap_bit = 1'b0;
        for (int i = 0; i < SEGS; i++) begin
            if (seg_sel == SEL_W'(i)) begin
                tap_bit = seg_taps[i];
            end
        end
    end

endmodule

// File: rtl/srl_tap_reg.sv
module srl_tap_reg (
    input  logic clk,
    input  logic shift_en,
    input  logic d_bit,
    output logic q_bit
);

    typedef struct packed {
        logic held;
    } treg_state_t;

    treg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.held = d_bit;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q_bit = state_q.held;

endmodule

// File: rtl/srl_delay_line.sv
module srl_delay_line
    import srl_pkg::*;
#(
    parameter  int SEGS    = 4,
    parameter  bit TAP_REG = 1'b1,
    localparam int ADDR_W  = chain_addr_w(SEGS)
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              din,
    input  logic [ADDR_W-1:0] tap_addr,
    output logic              tap_out,
    output logic              tap_reg_out,
    output logic [SEGS-1:0]   casc_out
);

    localparam int SEL_W = seg_sel_w(SEGS);

    logic [SEGS-1:0]  seg_in;
    logic [SEGS-1:0]  seg_tap;
    logic [SEGS-1:0]  seg_last;
    logic [SEL_W-1:0] seg_sel;

    // Segment chain: each segment's last stage feeds the next one.
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        if (k == 0) begin : g_head
            assign seg_in[k] = din;
        end else begin : g_link
            assign seg_in[k] = seg_last[k-1];
        end

        srl_segment i_seg (
            .clk      (clk),
            .shift_en (shift_en),
            .ser_in   (seg_in[k]),
            .tap_idx  (tap_addr[IDX_W-1:0]),
            .tap_bit  (seg_tap[k]),
            .last_bit (seg_last[k])
        );
    end

    assign casc_out = seg_last;

    // Upper address bits pick the segment; a single segment needs none.
    if (SEGS > 1) begin : g_multi
        assign seg_sel = tap_addr[ADDR_W-1:IDX_W];
    end else begin : g_single
        assign seg_sel = '0;
    end

    srl_tap_select #(.SEGS(SEGS)) i_sel (
        .seg_taps (seg_tap),
        .seg_sel  (seg_sel),
        .tap_bit  (tap_out)
    );

    // Optional enabled flip-flop after the tap multiplexer.
    if (TAP_REG) begin : g_treg
        srl_tap_reg i_treg (
            .clk      (clk),
            .shift_en (shift_en),
            .d_bit    (tap_out),
            .q_bit    (tap_reg_out)
        );
    end else begin : g_tpass
        assign tap_reg_out = tap_out;
    end

endmodule

// File: rtl/srl_delay_chk.sv
module srl_delay_chk #(
    parameter int SEGS    = 4,
    parameter bit TAP_REG = 1'b1,
    parameter int ADDR_W  = 6
) (
    input logic              clk,
    input logic              shift_en,
    input logic              din,
    input logic [ADDR_W-1:0] tap_addr,
    input logic              tap_out,
    input logic              tap_reg_out,
    input logic [SEGS-1:0]   casc_out
);

    // Becomes 1 after the first edge so $past never reaches before time zero.
    logic warm_q = 1'b0;
    always_ff @(posedge clk) warm_q <= 1'b1;

    // R1: after an enabled edge, address 0 shows the bit just taken in.
    a_r1_stage0_takes_din: assert property (@(posedge clk) disable iff (!warm_q)
        shift_en |=> ((tap_addr != '0) || (tap_out == $past(din))));

    // R2: disabled edges leave the segment ends untouched.
    a_r2_hold_casc: assert property (@(posedge clk) disable iff (!warm_q)
        !shift_en |=> $stable(casc_out));

    // R2: disabled edges leave the registered tap untouched.
    a_r2_hold_treg: assert property (@(posedge clk) disable iff (!warm_q)
        !shift_en |=> $stable(tap_reg_out));

    // R4: address 15 reads the same stage the first segment exposes as its end.
    a_r4_casc_is_last: assert property (@(posedge clk) disable iff (!warm_q)
        (tap_addr == ADDR_W'(15)) |-> (tap_out == casc_out[0]));

    // R5: the first stage of segment 1 takes the previous end of segment 0.
    if (SEGS > 1) begin : g_link_chk
        a_r5_segment_link: assert property (@(posedge clk) disable iff (!warm_q)
            shift_en |=> ((tap_addr != ADDR_W'(16)) || (tap_out == $past(casc_out[0]))));
    end

    // R6: registered tap follows the tap by one enabled edge, or is transparent.
    if (TAP_REG) begin : g_treg_chk
        a_r6_treg_loads: assert property (@(posedge clk) disable iff (!warm_q)
            shift_en |=> (tap_reg_out == $past(tap_out)));
    end else begin : g_tpass_chk
        a_r6_treg_transparent: assert property (@(posedge clk) disable iff (!warm_q)
            tap_reg_out == tap_out);
    end

endmodule

bind srl_delay_line srl_delay_chk #(
    .SEGS    (SEGS),
    .TAP_REG (TAP_REG),
    .ADDR_W  (ADDR_W)
) i_chk (.*);

// File: tb/test_srl_delay_line.sv
`timescale 1ns/1ps
module test_srl_delay_line;
    import srl_pkg::*;

    localparam int SEGS   = 4;
    localparam bit TREG   = 1'b1;
    localparam int ADDR_W = chain_addr_w(SEGS);
    localparam int DEPTH  = SEG_LEN * SEGS;

    logic              clk = 1'b0;
    logic              shift_en = 1'b0;
    logic              din = 1'b0;
    logic [ADDR_W-1:0] tap_addr = '0;
    logic              tap_out;
    logic              tap_reg_out;
    logic [SEGS-1:0]   casc_out;

    srl_delay_line #(.SEGS(SEGS), .TAP_REG(TREG)) i_srl_delay_line (
        .clk         (clk),
        .shift_en    (shift_en),
        .din         (din),
        .tap_addr    (tap_addr),
        .tap_out     (tap_out),
        .tap_reg_out (tap_reg_out),
        .casc_out    (casc_out)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // Reference: hist[j] is the din taken j+1 enabled edges ago.
    bit hist [0:DEPTH];
    int fills = 0;
    bit exp_reg = 1'b0;
    bit reg_known = 1'b0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: inputs change at the falling edge, checks follow 1 ns after the rise.
    task automatic step(bit d, bit en, logic [ADDR_W-1:0] a);
        @(negedge clk);
        din = d;
        shift_en = en;
        tap_addr = a;
        @(posedge clk);
        if (en) begin
            exp_reg   = hist[a];
            reg_known = (fills > int'(a));
            for (int i = DEPTH; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = d;
            fills++;
        end
        #1;
        shift_en = 1'b0;
    endtask

    task automatic sweep(string req);
        for (int a = 0; a < DEPTH; a++) begin
            tap_addr = ADDR_W'(a);
            #0.2;
            if (fills > a) check(req, 64'(tap_out), 64'(hist[a]), $sformatf("tap addr %0d", a));
        end
    endtask

    task automatic check_casc(string req);
        for (int k = 0; k < SEGS; k++) begin
            if (fills > SEG_LEN*k + SEG_LEN-1)
                check(req, 64'(casc_out[k]), 64'(hist[SEG_LEN*k + SEG_LEN-1]),
                      $sformatf("segment end %0d", k));
        end
    endtask

    // R5/R4: flush the whole chain, then read every stage and every segment end.
    task automatic t_fill();
        for (int n = 0; n < DEPTH + 8; n++) step(1'($urandom), 1'b1, ADDR_W'($urandom_range(0, DEPTH-1)));
        sweep("R5");
        check_casc("R4");
    endtask

    // R1: address 0 is the last bit taken; address 1 the one before it.
    task automatic t_first_stage();
        bit prev = hist[0];
        for (int n = 0; n < 8; n++) begin
            bit d = 1'($urandom);
            step(d, 1'b1, '0);
            check("R1", 64'(tap_out), 64'(d), "stage 0");
            tap_addr = ADDR_W'(1);
            #0.2;
            check("R1", 64'(tap_out), 64'(prev), "stage 1");
            prev = d;
        end
    endtask

    // R2: din toggles with the enable low; nothing may move.
    task automatic t_hold();
        logic [SEGS-1:0] casc_snap = casc_out;
        logic            treg_snap = tap_reg_out;
        for (int n = 0; n < 12; n++) step(n[0], 1'b0, ADDR_W'($urandom_range(0, DEPTH-1)));
        sweep("R2");
        check("R2", 64'(casc_out), 64'(casc_snap), "segment ends after disabled cycles");
        check("R2", 64'(tap_reg_out), 64'(treg_snap), "registered tap after disabled cycles");
    endtask

    // R6: the registered tap holds the tap value from the edge, one enabled cycle later.
    task automatic t_treg();
        int addrs [7] = '{0, 5, 15, 16, 40, 62, 63};
        foreach (addrs[i]) begin
            step(1'($urandom), 1'b1, ADDR_W'(addrs[i]));
            if (reg_known) check("R6", 64'(tap_reg_out), 64'(exp_reg), $sformatf("registered tap addr %0d", addrs[i]));
            check("R6", 64'(tap_reg_out), 64'(hist[addrs[i]+1]), $sformatf("extra delay addr %0d", addrs[i]));
        end
    endtask

    // R3: address moves in the same cycle as random enabled and disabled edges.
    task automatic t_gaps();
        for (int n = 0; n < 300; n++) begin
            int a = $urandom_range(0, DEPTH-1);
            step(1'($urandom), ($urandom_range(0, 2) != 0), ADDR_W'(a));
            if (fills > a) check("R3", 64'(tap_out), 64'(hist[a]), $sformatf("tap addr %0d step %0d", a, n));
            if (reg_known) check("R6", 64'(tap_reg_out), 64'(exp_reg), $sformatf("registered tap step %0d", n));
            if (n % 16 == 0) check_casc("R4");
        end
    endtask

    initial begin
        t_fill();
        t_first_stage();
        t_hold();
        t_treg();
        t_gaps();
        sweep("R3");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule